// File: doc/BRIEF.md
# Multibank DRAM Bank Sequencer

This block sits between a memory master and up to four independently addressed DRAM banks. The master presents one cache-line request at a time: a bank number, a row, a starting column, a write flag and a flag that selects extended-data-out (EDO) read timing. When the target bank is idle, the block accepts the request. For that bank alone, it then plays out a page-mode sequence: the row strobe with the row address, two column strobes for the two 16-byte halves of the 32-byte line, and a precharge cycle. Each beat is 128 data bits plus 16 check bits wide on the data path.

Every bank has its own timer and its own RAS, CAS, WE and address pins, so sequences on different banks overlap freely. A request to a bank that is still running is held off through `req_ready`. Even banks feed RAM data bus A and odd banks feed bus B. The per-bank read and write beat strobes tell the data path which cycle carries each beat. The length of a sequence depends only on the access type.

Top module: `dram_bank_seq`

## Requirements
- R1: While `rst` is high and in the cycle after it, every `ras_n`, `cas_n` and `we_n` bit is 1, and every `bank_busy`, `rd_beat` and `wr_beat` bit is 0. Every `dram_addr` field is 0.
- R2: A request is accepted at a clock edge where `req_valid` and `req_ready` are both 1. In the following cycle (step 1), bank `req_bank` has `bank_busy` = 1, `ras_n` = 0 and its address field equal to `req_row`.
- R3: Column strobe `cas_n` is 0 in exactly two steps: step 2, with the address field equal to `req_col`, and step L-1, with the address field equal to `req_col`+1. In every other cycle `cas_n` is 1, and `cas_n` is never 0 while `ras_n` is 1.
- R4: The sequence length L is set by the access type. L is 4 for an EDO read (`req_write`=0, `req_edo`=1), 5 for a plain read (`req_write`=0, `req_edo`=0) and 6 for a write (`req_write`=1, `req_edo` ignored).
- R5: `bank_busy` is 1 in steps 1 to L and 0 from step L+1, which is the cycle after the last column strobe rises. `ras_n` is 0 in steps 1 to L-1 and 1 in step L, the precharge step.
- R6: For write sequences, `we_n` is 0 in steps 2 to L-1. For reads, `we_n` stays 1.
- R7: `req_ready` is the inverse of `bank_busy` for the bank selected by `req_bank`. A request presented while `req_ready` is 0 is dropped and leaves the running sequence unchanged.
- R8: Sequences on different banks run at the same time without affecting one another.
- R9: `rd_beat` is 1 in each column-strobe step of a read and `wr_beat` is 1 in each column-strobe step of a write. At all other times both are 0.
- R10: A bank's address field is 0 in every cycle that is not step 1 or a column-strobe step.
- R11: The second column address is `req_col`+1 modulo 2^COL_W, so a starting column of all ones wraps to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_bank | input | BANK_W (2) | Target bank; bit 0 picks RAM data bus A (0) or B (1) |
| req_row | input | ROW_W (12) | Row address |
| req_col | input | COL_W (10) | Starting column of the line |
| req_write | input | 1 | 1 = write line, 0 = read line |
| req_edo | input | 1 | 1 = EDO read timing (reads only) |
| req_ready | output | 1 | Selected bank can take the request |
| bank_busy | output | NUM_BANKS | Per-bank sequence running |
| ras_n | output | NUM_BANKS | Per-bank row strobe, active low |
| cas_n | output | NUM_BANKS | Per-bank column strobe, active low |
| we_n | output | NUM_BANKS | Per-bank write enable, active low |
| dram_addr | output | NUM_BANKS*ADDR_W (48) | Per-bank multiplexed address, bank i at bits [i*ADDR_W +: ADDR_W] |
| rd_beat | output | NUM_BANKS | Read beat present on the bank's data bus |
| wr_beat | output | NUM_BANKS | Write beat taken from the bank's data bus |

## Verification
Every pin of a bank is registered. The row strobe appears in the first cycle after the accepting edge. The first column strobe follows one cycle later. The second column strobe comes in step L-1, and busy drops L+1 cycles after the accepting edge. The ready output is combinational from the registered busy flags and the present `req_bank`, so it is due in the same cycle. The bench keeps a behavioural model of each bank as a step count. It advances that model at each rising edge from the inputs it drove, then compares all outputs at the following falling edge. It checks `req_ready` shortly after it drives the inputs. Because of this, every check lands in the cycle counted above.

// File: rtl/dbs_pkg.sv
package dbs_pkg;

  typedef enum logic [1:0] {
    ACC_EDO_RD = 2'd0,
    ACC_RD     = 2'd1,
    ACC_WR     = 2'd2
  } acc_kind_t;

  localparam int unsigned STEP_W = 3;

  localparam logic [STEP_W-1:0] LEN_EDO_RD = 3'd4;
  localparam logic [STEP_W-1:0] LEN_RD     = 3'd5;
  localparam logic [STEP_W-1:0] LEN_WR     = 3'd6;

  // Busy cycles of a two-beat page-mode line, fixed per access type
  function automatic logic [STEP_W-1:0] acc_len(acc_kind_t k);
    case (k)
      ACC_EDO_RD: acc_len = LEN_EDO_RD;
      ACC_RD:     acc_len = LEN_RD;
      default:    acc_len = LEN_WR;
    endcase
  endfunction

endpackage

// File: rtl/dbs_req_route.sv
module dbs_req_route
  import dbs_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BANK_W    = 2
) (
  input  logic                 req_valid,
  input  logic [BANK_W-1:0]    req_bank,
  input  logic                 req_write,
  input  logic                 req_edo,
  input  logic [NUM_BANKS-1:0] busy,
  output logic                 req_ready,
  output logic [NUM_BANKS-1:0] start,
  output acc_kind_t            kind
);

  assign req_ready = !busy[req_bank];

  always_comb begin
    if (req_write)    kind = ACC_WR;
    else if (req_edo) kind = ACC_EDO_RD;
    else              kind = ACC_RD;
  end

  for (genvar i = 0; i < NUM_BANKS; i++) begin : g_sel
    assign start[i] = req_valid && req_ready && (req_bank == BANK_W'(i));
  end

endmodule

// File: rtl/dbs_bank_timer.sv
module dbs_bank_timer
  import dbs_pkg::*;
#(
  parameter int ROW_W  = 12,
  parameter int COL_W  = 10,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  acc_kind_t         kind_in,
  input  logic [ROW_W-1:0]  row_in,
  input  logic [COL_W-1:0]  col_in,
  output logic              busy,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [ADDR_W-1:0] addr,
  output logic              rd_beat,
  output logic              wr_beat
);

  logic [STEP_W-1:0] step_q, step_d, cas2_d;
  acc_kind_t         kind_q, kind_d;
  logic [ROW_W-1:0]  row_q, row_d;
  logic [COL_W-1:0]  col_q, col_d, col_inc;
  logic              is_cas, ras_d, cas_d, we_d, rd_d, wr_d;
  logic [ADDR_W-1:0] addr_d;

  always_comb begin
    step_d = step_q;
    kind_d = kind_q;
    row_d  = row_q;
    col_d  = col_q;
    if (start) begin
      step_d = 3'd1;
      kind_d = kind_in;
      row_d  = row_in;
      col_d  = col_in;
    end else if (step_q != '0) begin
      step_d = (step_q == acc_len(kind_q)) ? '0 : step_q + 3'd1;
    end

    // outputs for the next cycle, decoded from the next step
    cas2_d  = acc_len(kind_d) - 3'd1;
    col_inc = col_d + COL_W'(1);
    is_cas  = (step_d == 3'd2) || (step_d == cas2_d);
    ras_d   = !((step_d != '0) && (step_d <= cas2_d));
    cas_d   = !is_cas;
    we_d    = !((kind_d == ACC_WR) && (step_d >= 3'd2) && (step_d <= cas2_d));
    rd_d    = is_cas && (kind_d != ACC_WR);
    wr_d    = is_cas && (kind_d == ACC_WR);
    addr_d  = '0;
    if (step_d == 3'd1)      addr_d = ADDR_W'(row_d);
    else if (step_d == 3'd2) addr_d = ADDR_W'(col_d);
    else if (is_cas)         addr_d = ADDR_W'(col_inc);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      step_q  <= '0;
      kind_q  <= ACC_RD;
      row_q   <= '0;
      col_q   <= '0;
      busy    <= 1'b0;
      ras_n   <= 1'b1;
      cas_n   <= 1'b1;
      we_n    <= 1'b1;
      addr    <= '0;
      rd_beat <= 1'b0;
      wr_beat <= 1'b0;
    end else begin
      step_q  <= step_d;
      kind_q  <= kind_d;
      row_q   <= row_d;
      col_q   <= col_d;
      busy    <= (step_d != '0);
      ras_n   <= ras_d;
      cas_n   <= cas_d;
      we_n    <= we_d;
      addr    <= addr_d;
      rd_beat <= rd_d;
      wr_beat <= wr_d;
    end
  end

endmodule

// File: rtl/dram_bank_seq.sv
module dram_bank_seq
  import dbs_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 12,
  parameter int COL_W     = 10,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int ADDR_W   = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        req_valid,
  input  logic [BANK_W-1:0]           req_bank,
  input  logic [ROW_W-1:0]            req_row,
  input  logic [COL_W-1:0]            req_col,
  input  logic                        req_write,
  input  logic                        req_edo,
  output logic                        req_ready,
  output logic [NUM_BANKS-1:0]        bank_busy,
  output logic [NUM_BANKS-1:0]        ras_n,
  output logic [NUM_BANKS-1:0]        cas_n,
  output logic [NUM_BANKS-1:0]        we_n,
  output logic [NUM_BANKS*ADDR_W-1:0] dram_addr,
  output logic [NUM_BANKS-1:0]        rd_beat,
  output logic [NUM_BANKS-1:0]        wr_beat
);

  logic [NUM_BANKS-1:0] start;
  acc_kind_t            kind;

  dbs_req_route #(
    .NUM_BANKS (NUM_BANKS),
    .BANK_W    (BANK_W)
  ) u_route (
    .req_valid (req_valid),
    .req_bank  (req_bank),
    .req_write (req_write),
    .req_edo   (req_edo),
    .busy      (bank_busy),
    .req_ready (req_ready),
    .start     (start),
    .kind      (kind)
  );

  for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
    dbs_bank_timer #(
      .ROW_W  (ROW_W),
      .COL_W  (COL_W),
      .ADDR_W (ADDR_W)
    ) u_timer (
      .clk     (clk),
      .rst     (rst),
      .start   (start[i]),
      .kind_in (kind),
      .row_in  (req_row),
      .col_in  (req_col),
      .busy    (bank_busy[i]),
      .ras_n   (ras_n[i]),
      .cas_n   (cas_n[i]),
      .we_n    (we_n[i]),
      .addr    (dram_addr[i*ADDR_W +: ADDR_W]),
      .rd_beat (rd_beat[i]),
      .wr_beat (wr_beat[i])
    );
  end

endmodule

// File: rtl/dbs_bank_seq_chk.sv
module dbs_bank_seq_chk #(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 12,
  parameter int COL_W     = 10,
  parameter int BANK_W    = 2,
  parameter int ADDR_W    = 12
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        req_valid,
  input logic [BANK_W-1:0]           req_bank,
  input logic [ROW_W-1:0]            req_row,
  input logic [COL_W-1:0]            req_col,
  input logic                        req_write,
  input logic                        req_edo,
  input logic                        req_ready,
  input logic [NUM_BANKS-1:0]        bank_busy,
  input logic [NUM_BANKS-1:0]        ras_n,
  input logic [NUM_BANKS-1:0]        cas_n,
  input logic [NUM_BANKS-1:0]        we_n,
  input logic [NUM_BANKS*ADDR_W-1:0] dram_addr,
  input logic [NUM_BANKS-1:0]        rd_beat,
  input logic [NUM_BANKS-1:0]        wr_beat
);

  for (genvar i = 0; i < NUM_BANKS; i++) begin : g_chk
    // R2
    row_open_chk: assert property (@(posedge clk) disable iff (rst)
      (req_valid && req_ready && req_bank == BANK_W'(i)) |=>
        (bank_busy[i] && !ras_n[i] &&
         dram_addr[i*ADDR_W +: ADDR_W] == ADDR_W'($past(req_row))));
    // R3
    cas_in_row_chk: assert property (@(posedge clk) disable iff (rst)
      !cas_n[i] |-> !ras_n[i]);
    // R5
    precharge_end_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(bank_busy[i]) |-> ($past(ras_n[i]) && $past(cas_n[i])));
    // R6
    we_in_seq_chk: assert property (@(posedge clk) disable iff (rst)
      !we_n[i] |-> (bank_busy[i] && !ras_n[i]));
    // R7
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (bank_busy[i] && req_bank == BANK_W'(i)) |-> !req_ready);
    // R9
    beat_strobe_chk: assert property (@(posedge clk) disable iff (rst)
      (rd_beat[i] || wr_beat[i]) |->
        (!cas_n[i] && $onehot0({rd_beat[i], wr_beat[i]}) && (wr_beat[i] == !we_n[i])));
  end

endmodule

bind dram_bank_seq dbs_bank_seq_chk #(
  .NUM_BANKS (NUM_BANKS),
  .ROW_W     (ROW_W),
  .COL_W     (COL_W),
  .BANK_W    (BANK_W),
  .ADDR_W    (ADDR_W)
) u_chk (.*);

// File: tb/test_dram_bank_seq.sv
module test_dram_bank_seq;

  localparam int NB    = 4;
  localparam int ROW_W = 12;
  localparam int COL_W = 10;
  localparam int BW    = 2;
  localparam int AW    = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [BW-1:0] req_bank = '0;
  logic [ROW_W-1:0] req_row = '0;
  logic [COL_W-1:0] req_col = '0;
  logic req_write = 1'b0;
  logic req_edo = 1'b0;
  logic req_ready;
  logic [NB-1:0] bank_busy, ras_n, cas_n, we_n, rd_beat, wr_beat;
  logic [NB*AW-1:0] dram_addr;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // model: per bank step (0 idle), kind (0 EDO read, 1 read, 2 write)
  int m_step[NB];
  int m_kind[NB];
  int m_row[NB];
  int m_col[NB];

  always #5 clk = ~clk;

  dram_bank_seq #(.NUM_BANKS(NB), .ROW_W(ROW_W), .COL_W(COL_W)) i_dram_bank_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_bank(req_bank),
    .req_row(req_row), .req_col(req_col), .req_write(req_write), .req_edo(req_edo),
    .req_ready(req_ready), .bank_busy(bank_busy), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .dram_addr(dram_addr), .rd_beat(rd_beat), .wr_beat(wr_beat));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int len_of(int k);
    return (k == 0) ? 4 : (k == 1) ? 5 : 6;
  endfunction

  task automatic compare_all();
    for (int b = 0; b < NB; b++) begin
      int s = m_step[b];
      int l = len_of(m_kind[b]);
      bit cas = (s == 2) || (s == l - 1);
      int ea = 0;
      string at = "R10";
      if (s == 1) begin ea = m_row[b]; at = "R2"; end
      else if (s == 2) begin ea = m_col[b]; at = "R3"; end
      else if (s == l - 1 && s != 0) begin ea = (m_col[b] + 1) % (1 << COL_W); at = "R3"; end
      check(bank_busy[b] == (s != 0), "R5 busy", bank_busy[b], s != 0);
      check(ras_n[b] == !(s >= 1 && s <= l - 1), "R5 ras_n", ras_n[b], !(s >= 1 && s <= l - 1));
      check(cas_n[b] == !cas, "R3 cas_n", cas_n[b], !cas);
      check(we_n[b] == !(m_kind[b] == 2 && s >= 2 && s <= l - 1), "R6 we_n", we_n[b],
            !(m_kind[b] == 2 && s >= 2 && s <= l - 1));
      check(int'(dram_addr[b*AW +: AW]) == ea, at, dram_addr[b*AW +: AW], ea);
      check(rd_beat[b] == (cas && m_kind[b] != 2), "R9 rd_beat", rd_beat[b], cas && m_kind[b] != 2);
      check(wr_beat[b] == (cas && m_kind[b] == 2), "R9 wr_beat", wr_beat[b], cas && m_kind[b] == 2);
    end
  endtask

  // one cycle: drive at falling edge, step model at rising edge, compare at next falling edge
  task automatic cyc(input bit v, input int bank, input int row, input int col,
                     input bit wr, input bit edo);
    bit acc;
    req_valid = v; req_bank = BW'(bank); req_row = ROW_W'(row);
    req_col = COL_W'(col); req_write = wr; req_edo = edo;
    #1;
    check(req_ready == (m_step[bank] == 0), "R7 ready", req_ready, m_step[bank] == 0);
    acc = v && (m_step[bank] == 0);
    @(posedge clk);
    for (int b = 0; b < NB; b++)
      if (m_step[b] != 0) m_step[b] = (m_step[b] == len_of(m_kind[b])) ? 0 : m_step[b] + 1;
    if (acc) begin
      m_step[bank] = 1;
      m_kind[bank] = wr ? 2 : (edo ? 0 : 1);   // R4: edo ignored on writes
      m_row[bank]  = row;
      m_col[bank]  = col;
    end
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) cyc(0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    for (int b = 0; b < NB; b++) begin
      m_step[b] = 0; m_kind[b] = 1; m_row[b] = 0; m_col[b] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset values
    check(ras_n == '1 && cas_n == '1 && we_n == '1, "R1 strobes", {ras_n, cas_n, we_n}, 12'hFFF);
    check(bank_busy == '0 && rd_beat == '0 && wr_beat == '0, "R1 flags",
          {bank_busy, rd_beat, wr_beat}, 0);
    check(dram_addr == '0, "R1 addr", 0, 0);
    rst = 1'b0;

    cyc(1, 0, 12'h0A5, 10'h010, 0, 1); idle(5);   // EDO read, R4
    cyc(1, 1, 12'h123, 10'h1F0, 0, 0); idle(6);   // plain read
    cyc(1, 2, 12'hFFF, 10'h2A2, 1, 1); idle(7);   // write, edo ignored

    // R11 column wrap on an EDO read
    cyc(1, 3, 12'h055, 10'h3FF, 0, 1);
    idle(2);
    check(dram_addr[3*AW +: AW] == '0 && !cas_n[3], "R11 wrap",
          dram_addr[3*AW +: AW], 0);
    idle(3);

    // R8 all four banks overlapping
    cyc(1, 0, 12'h111, 10'h001, 1, 0);
    cyc(1, 1, 12'h222, 10'h002, 0, 1);
    cyc(1, 2, 12'h333, 10'h003, 0, 0);
    cyc(1, 3, 12'h444, 10'h004, 1, 0);
    check(bank_busy == 4'hF, "R8 overlap", bank_busy, 4'hF);
    idle(8);

    // R7 request to a busy bank is dropped
    cyc(1, 0, 12'h0F0, 10'h0F0, 0, 0);
    cyc(1, 0, 12'h00F, 10'h00F, 1, 0);
    check(we_n[0] == 1'b1, "R7 dropped", we_n[0], 1);
    idle(7);

    // mixed traffic
    for (int k = 0; k < 400; k++)
      cyc(1'($urandom_range(0, 1)), $urandom_range(0, NB - 1), $urandom_range(0, 4095),
          $urandom_range(0, 1023), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
    idle(8);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule